// File: doc/BRIEF.md
# ISA Byte-Lane Steering Bridge

This block sits between a 32-bit processor bus, whose data path reaches peripherals only on bits 0 to 15, and an 8/16-bit ISA-style I/O bus. For each request it decodes the processor offset into the I/O window and the transfer size. From them it derives the peripheral port number, including the level of peripheral address bit 0, and the byte lanes to drive. It then runs one or two strobed bus cycles and returns a single completion.

Byte registers at odd ports are reached in two ways. The first is a word-sized request to the even offset just below the port. The bridge raises peripheral A0 and moves the byte on the low lane. The second is a plain byte request to the odd offset, which moves the byte on the high lane for 16-bit peripherals that expect odd bytes there. A small legacy window for the serial and parallel ports uses a stride of four bytes per port and needs neither method. Requests that cannot be carried out return an error and never reach the bus. A paired-halfword request is split into two 16-bit cycles.

Top module: `isa_lane_bridge`

## Requirements
- R1: A byte request (size code 0) at an even offset `o` outside the legacy window runs one cycle to port `o>>1` with A0=0 and lane mask 2'b01. Write data bits 7:0 go on bus bits 7:0. Read data returns bus bits 7:0, zero-extended.
- R2: A word request (size code 2) at an offset with bits 1:0 equal to 0 outside the legacy window is an odd-byte access. It runs one cycle to port `(o>>1)|1`, so A0=1, with lane mask 2'b01 and the byte on bus bits 7:0. A read returns that byte zero-extended in read data bits 7:0.
- R3: A byte request at an odd offset `o` outside the legacy window runs one cycle to port `(o>>1)|1` with lane mask 2'b10. Write data bits 7:0 go on bus bits 15:8, and a read returns bus bits 15:8 zero-extended.
- R4: An offset is in the legacy window when `o>>5` equals `p>>3` for one of the port groups 0x3F8, 0x2F8 or 0x378. There the port is `o>>2`. A byte request runs one low-lane cycle with A0 equal to port bit 0. An offset with bits 1:0 not zero, or size code 2 or 3, is an error.
- R5: A halfword request (size code 1) to an even port runs one cycle with lane mask 2'b11. It carries write data bits 15:0, and a read returns bus bits 15:0 zero-extended.
- R6: A halfword request to an odd port is an error. This covers an odd offset in the general region and a legacy offset whose bit 2 is set. The error is reported and no strobe is driven.
- R7: A paired-halfword request (size code 3) at an offset with bits 2:0 equal to 0 runs two 16-bit cycles. The first goes to port `o>>1` with data bits 15:0, and the second to that port plus 2 (offset plus 4) with data bits 31:16. A read assembles the halves in the same positions. Any other offset is an error.
- R8: Outside the legacy window, an offset with bit 1 set or the top offset bit set is an error. So is a word request at an odd offset. None of them drives a strobe.
- R9: Each cycle holds the read or write strobe low for `max(cfg_strobe_len,1)` clocks, using the value latched at acceptance, then holds for one clock with the strobe high. Address and lanes stay stable for the whole cycle. Data is driven (`isa_oe`) only on writes, and the two strobes are never low together.
- R10: A read captures the bus on the last clock of its strobe.
- R11: A request is taken when `cpu_valid` is high while the bridge is idle. The request inputs are ignored until completion. Completion is a one-clock `cpu_ready` pulse with `cpu_err` and `cpu_rdata`.
- R12: While reset is held, both strobes are high, `isa_oe`, `cpu_ready` and the lane mask are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| cfg_strobe_len | input | STRB_W | strobe length in clocks, 0 treated as 1 |
| cpu_valid | input | 1 | request present |
| cpu_addr | input | PORT_W+2 | offset into the I/O window |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word (odd byte), 3 paired halfword |
| cpu_write | input | 1 | 1 write, 0 read |
| cpu_wdata | input | 32 | write data |
| cpu_ready | output | 1 | one-clock completion pulse |
| cpu_rdata | output | 32 | read data, valid with ready |
| cpu_err | output | 1 | illegal request, valid with ready |
| isa_addr | output | PORT_W | peripheral port, bit 0 is A0 |
| isa_lane | output | 2 | active lanes: bit 0 low byte, bit 1 high byte |
| isa_rd_n | output | 1 | read strobe, active low |
| isa_wr_n | output | 1 | write strobe, active low |
| isa_oe | output | 1 | bridge drives isa_dout |
| isa_dout | output | 16 | bus write data |
| isa_din | input | 16 | bus read data |

## Verification
The hardest case to reach from the ports is showing that read data is taken on the last strobe clock and not earlier or later. The bench's peripheral model presents the port-dependent value only while it has counted exactly the expected number of low strobe clocks, and a marker value at all other times. A capture taken one clock off therefore returns the marker. The second half of a paired-halfword read is the other hard case. It starts straight after the hold clock, at a new address, so the model has to re-arm its count and serve the new port. Strobe lengths of 0, 1, 3 and 15 are mixed across the cases.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_TRICK = 2'd2,
      SZ_SPLIT = 2'd3
   } xfer_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_STRB = 2'd1,
      ST_HOLD = 2'd2,
      ST_DONE = 2'd3
   } seq_state_e;

   localparam int LEG_N = 3;
   localparam logic [11:0] LEG_BASE [LEG_N] = '{12'h3F8, 12'h2F8, 12'h378};
endpackage

// File: rtl/isa_addr_decode.sv
module isa_addr_decode
   import isa_bridge_pkg::*;
#(
   parameter int PORT_W    = 12,
   parameter bit LEGACY_EN = 1'b1,
   localparam int OFS_W    = PORT_W + 2
) (
   input  logic [OFS_W-1:0]  ofs,
   input  xfer_size_e        size,
   output logic              err,
   output logic [PORT_W-1:0] port,
   output logic [1:0]        lanes,
   output logic              split
);
   logic leg;

   generate
      if (LEGACY_EN) begin : g_leg
         logic [LEG_N-1:0] hit;
         for (genvar i = 0; i < LEG_N; i++) begin : g_grp
            localparam logic [PORT_W-1:0] BASE = PORT_W'(LEG_BASE[i]);
            assign hit[i] = (ofs[OFS_W-1:5] == BASE[PORT_W-1:3]);
         end
         assign leg = |hit;
      end else begin : g_noleg
         assign leg = 1'b0;
      end
   endgenerate

   always_comb begin
      err   = 1'b0;
      port  = '0;
      lanes = 2'b00;
      split = 1'b0;
      if (leg) begin
         port = ofs[OFS_W-1:2];
         if (ofs[1:0] != 2'b00) err = 1'b1;
         else begin
            case (size)
               SZ_BYTE: lanes = 2'b01;
               SZ_HALF: if (ofs[2]) err = 1'b1; else lanes = 2'b11;
               default: err = 1'b1;
            endcase
         end
      end else if (ofs[OFS_W-1] || ofs[1]) begin
         err = 1'b1;
      end else begin
         port = {ofs[OFS_W-2:2], 1'b0};
         case (size)
            SZ_BYTE: begin
               port[0] = ofs[0];
               lanes   = ofs[0] ? 2'b10 : 2'b01;
            end
            SZ_HALF: if (ofs[0]) err = 1'b1; else lanes = 2'b11;
            SZ_TRICK: begin
               if (ofs[0]) err = 1'b1;
               else begin
                  port[0] = 1'b1;
                  lanes   = 2'b01;
               end
            end
            default: begin
               if (ofs[2:0] != 3'b000) err = 1'b1;
               else begin
                  lanes = 2'b11;
                  split = 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/isa_lane_steer.sv
module isa_lane_steer (
   input  logic [1:0]  lanes,
   input  logic        second,
   input  logic [31:0] wdata,
   input  logic [15:0] din,
   output logic [15:0] dout,
   output logic [15:0] rd_piece
);
   always_comb begin
      if (second)               dout = wdata[31:16];
      else if (lanes == 2'b10)  dout = {wdata[7:0], 8'h00};
      else if (lanes == 2'b01)  dout = {8'h00, wdata[7:0]};
      else                      dout = wdata[15:0];

      if (lanes == 2'b10)       rd_piece = {8'h00, din[15:8]};
      else if (lanes == 2'b01)  rd_piece = {8'h00, din[7:0]};
      else                      rd_piece = din;
   end
endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
   import isa_bridge_pkg::*;
#(
   parameter int PORT_W = 12,
   parameter int STRB_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STRB_W-1:0] cfg_strobe_len,
   input  logic              cpu_valid,
   input  logic              cpu_write,
   input  logic [31:0]       cpu_wdata,
   input  logic              dec_err,
   input  logic [PORT_W-1:0] dec_port,
   input  logic [1:0]        dec_lanes,
   input  logic              dec_split,
   input  logic [15:0]       rd_piece,
   output logic              acc,
   output logic              second_q,
   output logic [31:0]       wdata_q,
   output logic [1:0]        isa_lane,
   output logic [PORT_W-1:0] isa_addr,
   output logic              isa_rd_n,
   output logic              isa_wr_n,
   output logic              isa_oe,
   output logic              cpu_ready,
   output logic              cpu_err,
   output logic [31:0]       cpu_rdata
);
   seq_state_e        st;
   logic [STRB_W-1:0] cnt, len_q, eff_len;
   logic [1:0]        lanes_q;
   logic              write_q, split_q, in_cyc;

   assign eff_len  = (cfg_strobe_len == '0) ? STRB_W'(1) : cfg_strobe_len;
   assign acc      = (st == ST_IDLE) && cpu_valid;
   assign in_cyc   = (st == ST_STRB) || (st == ST_HOLD);
   assign isa_rd_n = !((st == ST_STRB) && !write_q);
   assign isa_wr_n = !((st == ST_STRB) && write_q);
   assign isa_oe   = in_cyc && write_q;
   assign isa_lane = in_cyc ? lanes_q : 2'b00;
   assign cpu_ready = (st == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         len_q     <= '0;
         lanes_q   <= 2'b00;
         write_q   <= 1'b0;
         split_q   <= 1'b0;
         second_q  <= 1'b0;
         wdata_q   <= '0;
         isa_addr  <= '0;
         cpu_err   <= 1'b0;
         cpu_rdata <= '0;
      end else begin
         case (st)
            ST_IDLE: if (cpu_valid) begin
               write_q   <= cpu_write;
               wdata_q   <= cpu_wdata;
               len_q     <= eff_len;
               cpu_rdata <= '0;
               cpu_err   <= dec_err;
               second_q  <= 1'b0;
               if (dec_err) st <= ST_DONE;
               else begin
                  isa_addr <= dec_port;
                  lanes_q  <= dec_lanes;
                  split_q  <= dec_split;
                  cnt      <= eff_len - STRB_W'(1);
                  st       <= ST_STRB;
               end
            end
            ST_STRB: begin
               if (cnt == '0) begin
                  if (!write_q) begin
                     if (second_q) cpu_rdata[31:16] <= rd_piece;
                     else          cpu_rdata        <= {16'h0000, rd_piece};
                  end
                  st <= ST_HOLD;
               end else begin
                  cnt <= cnt - STRB_W'(1);
               end
            end
            ST_HOLD: begin
               if (split_q && !second_q) begin
                  second_q <= 1'b1;
                  isa_addr <= isa_addr + PORT_W'(2);
                  cnt      <= len_q - STRB_W'(1);
                  st       <= ST_STRB;
               end else begin
                  st <= ST_DONE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // checker-side run counter for the strobe width
   logic [STRB_W:0] low_run;
   logic            strb_low;
   assign strb_low = !isa_rd_n || !isa_wr_n;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        low_run <= '0;
      else if (strb_low) low_run <= low_run + 1'b1;
      else               low_run <= '0;
   end

   assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(!isa_rd_n && !isa_wr_n));
   assert_strobe_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb_low && low_run != '0) |-> (low_run == {1'b0, len_q}));
   assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      strb_low |=> ($stable(isa_addr) && $stable(isa_lane)));
   assert_oe_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !isa_rd_n |-> !isa_oe);
   assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);
endmodule

// File: rtl/isa_lane_bridge.sv
module isa_lane_bridge
   import isa_bridge_pkg::*;
#(
   parameter int PORT_W    = 12,
   parameter int STRB_W    = 4,
   parameter bit LEGACY_EN = 1'b1,
   localparam int OFS_W    = PORT_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STRB_W-1:0] cfg_strobe_len,
   input  logic              cpu_valid,
   input  logic [OFS_W-1:0]  cpu_addr,
   input  logic [1:0]        cpu_size,
   input  logic              cpu_write,
   input  logic [31:0]       cpu_wdata,
   output logic              cpu_ready,
   output logic [31:0]       cpu_rdata,
   output logic              cpu_err,
   output logic [PORT_W-1:0] isa_addr,
   output logic [1:0]        isa_lane,
   output logic              isa_rd_n,
   output logic              isa_wr_n,
   output logic              isa_oe,
   output logic [15:0]       isa_dout,
   input  logic [15:0]       isa_din
);
   if (PORT_W < 10) begin : g_bad_port
      $error("PORT_W must cover the legacy port groups");
   end
   if (STRB_W < 1 || STRB_W > 8) begin : g_bad_strb
      $error("STRB_W out of range");
   end

   logic              dec_err, dec_split, acc, second_q;
   logic [PORT_W-1:0] dec_port;
   logic [1:0]        dec_lanes;
   logic [31:0]       wdata_q;
   logic [15:0]       rd_piece;
   xfer_size_e        size;

   assign size = xfer_size_e'(cpu_size);

   isa_addr_decode #(.PORT_W(PORT_W), .LEGACY_EN(LEGACY_EN)) u_dec (
      .ofs(cpu_addr), .size(size), .err(dec_err), .port(dec_port),
      .lanes(dec_lanes), .split(dec_split));

   isa_cycle_seq #(.PORT_W(PORT_W), .STRB_W(STRB_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cfg_strobe_len(cfg_strobe_len),
      .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_wdata(cpu_wdata),
      .dec_err(dec_err), .dec_port(dec_port), .dec_lanes(dec_lanes),
      .dec_split(dec_split), .rd_piece(rd_piece), .acc(acc),
      .second_q(second_q), .wdata_q(wdata_q), .isa_lane(isa_lane),
      .isa_addr(isa_addr), .isa_rd_n(isa_rd_n), .isa_wr_n(isa_wr_n),
      .isa_oe(isa_oe), .cpu_ready(cpu_ready), .cpu_err(cpu_err),
      .cpu_rdata(cpu_rdata));

   isa_lane_steer u_steer (
      .lanes(isa_lane), .second(second_q), .wdata(wdata_q), .din(isa_din),
      .dout(isa_dout), .rd_piece(rd_piece));

   assert_odd_half_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && size == SZ_HALF && cpu_addr[0]) |=> (cpu_ready && cpu_err));
   assert_trick_a0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && size == SZ_TRICK && !dec_err) |=> (isa_addr[0] && isa_lane == 2'b01));
   assert_err_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && dec_err) |=> (isa_rd_n && isa_wr_n && cpu_ready));
   assert_split_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(second_q) |-> (isa_addr == $past(isa_addr) + PORT_W'(2)));
endmodule

// File: tb/tb_isa_lane_bridge.sv
`timescale 1ns/1ps
module tb_isa_lane_bridge;
   localparam int PW = 12;
   localparam int OW = PW + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    cfg_strobe_len = 4'd2;
   logic          cpu_valid = 1'b0;
   logic [OW-1:0] cpu_addr = '0;
   logic [1:0]    cpu_size = 2'd0;
   logic          cpu_write = 1'b0;
   logic [31:0]   cpu_wdata = '0;
   logic          cpu_ready, cpu_err, isa_rd_n, isa_wr_n, isa_oe;
   logic [31:0]   cpu_rdata;
   logic [PW-1:0] isa_addr;
   logic [1:0]    isa_lane;
   logic [15:0]   isa_dout;
   logic [15:0]   isa_din = 16'hBAD0;

   always #2.5 clk = ~clk;

   isa_lane_bridge dut (
      .clk(clk), .rst_n(rst_n), .cfg_strobe_len(cfg_strobe_len),
      .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
      .cpu_write(cpu_write), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
      .cpu_rdata(cpu_rdata), .cpu_err(cpu_err), .isa_addr(isa_addr),
      .isa_lane(isa_lane), .isa_rd_n(isa_rd_n), .isa_wr_n(isa_wr_n),
      .isa_oe(isa_oe), .isa_dout(isa_dout), .isa_din(isa_din));

   typedef struct packed {
      logic [PW-1:0] port;
      logic [1:0]    lanes;
      logic          wr;
      logic [15:0]   dout;
      logic [4:0]    len;
   } cyc_t;
   typedef struct packed {
      logic        err;
      logic        wr;
      logic [31:0] rd;
   } done_t;

   cyc_t  cyc_q[$];
   done_t done_q[$];
   string cyc_tag_q[$];
   string done_tag_q[$];
   int    n_checks = 0;
   int    n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] periph(input logic [PW-1:0] p);
      return {~p[7:0], p[7:0] + 8'h3C};
   endfunction

   task automatic push_cyc(input logic [PW-1:0] p, input logic [1:0] ln, input bit wr,
                           input logic [15:0] d, input int len, input string tag);
      cyc_t c;
      c.port = p; c.lanes = ln; c.wr = wr; c.dout = d; c.len = 5'(len);
      cyc_q.push_back(c);
      cyc_tag_q.push_back(tag);
   endtask

   // reference model built from the requirements
   task automatic model(input logic [OW-1:0] o, input logic [1:0] sz, input bit wr,
                        input logic [31:0] wd, input int len, input string tag);
      bit            err = 1'b0;
      bit            leg;
      logic [PW-1:0] p;
      logic [15:0]   f, f2;
      logic [31:0]   rd = '0;
      done_t         d;
      int            ln = (len == 0) ? 1 : len;
      leg = (o[OW-1:5] == 9'h7F) || (o[OW-1:5] == 9'h5F) || (o[OW-1:5] == 9'h6F);
      if (leg) begin
         p = o[OW-1:2];
         f = periph(p);
         if (o[1:0] != 2'b00 || sz >= 2'd2) err = 1'b1;
         else if (sz == 2'd0) begin
            push_cyc(p, 2'b01, wr, {8'h00, wd[7:0]}, ln, tag);
            rd = {24'h0, f[7:0]};
         end else if (p[0]) err = 1'b1;
         else begin
            push_cyc(p, 2'b11, wr, wd[15:0], ln, tag);
            rd = {16'h0, f};
         end
      end else if (o[OW-1] || o[1]) begin
         err = 1'b1;
      end else begin
         p = {o[OW-2:2], 1'b0};
         case (sz)
            2'd0: begin
               if (!o[0]) begin
                  f = periph(p);
                  push_cyc(p, 2'b01, wr, {8'h00, wd[7:0]}, ln, tag);
                  rd = {24'h0, f[7:0]};
               end else begin
                  p[0] = 1'b1;
                  f = periph(p);
                  push_cyc(p, 2'b10, wr, {wd[7:0], 8'h00}, ln, tag);
                  rd = {24'h0, f[15:8]};
               end
            end
            2'd1: begin
               if (o[0]) err = 1'b1;
               else begin
                  f = periph(p);
                  push_cyc(p, 2'b11, wr, wd[15:0], ln, tag);
                  rd = {16'h0, f};
               end
            end
            2'd2: begin
               if (o[0]) err = 1'b1;
               else begin
                  p[0] = 1'b1;
                  f = periph(p);
                  push_cyc(p, 2'b01, wr, {8'h00, wd[7:0]}, ln, tag);
                  rd = {24'h0, f[7:0]};
               end
            end
            default: begin
               if (o[2:0] != 3'b000) err = 1'b1;
               else begin
                  f  = periph(p);
                  f2 = periph(p + PW'(2));
                  push_cyc(p, 2'b11, wr, wd[15:0], ln, tag);
                  push_cyc(p + PW'(2), 2'b11, wr, wd[31:16], ln, tag);
                  rd = {f2, f};
               end
            end
         endcase
      end
      d.err = err; d.wr = wr; d.rd = rd;
      done_q.push_back(d);
      done_tag_q.push_back(tag);
   endtask

   // driver: push expectations, then run the handshake
   task automatic xfer(input logic [OW-1:0] o, input logic [1:0] sz, input bit wr,
                       input logic [31:0] wd, input int len, input string tag);
      model(o, sz, wr, wd, len, tag);
      @(negedge clk);
      cfg_strobe_len = 4'(len);
      cpu_addr  = o;
      cpu_size  = sz;
      cpu_write = wr;
      cpu_wdata = wd;
      cpu_valid = 1'b1;
      @(posedge clk);
      #1;
      // R11: request inputs change while busy and must be ignored
      cpu_addr  = o ^ OW'(14'h1555);
      cpu_wdata = ~wd;
      cpu_size  = ~sz;
      cpu_write = ~wr;
      do @(negedge clk); while (!cpu_ready);
      cpu_valid = 1'b0;
   endtask

   // monitor: compares bus cycles and completions, models the peripheral
   bit   prev_low = 1'b0;
   int   run = 0;
   cyc_t cur;
   string cur_tag;
   always @(negedge clk) begin
      bit    low;
      done_t d;
      string t;
      if (rst_n) begin
         low = !isa_rd_n || !isa_wr_n;
         if (low && !prev_low) begin
            run = 0;
            if (cyc_q.size() == 0) begin
               chk(1'b0, "R8", "unexpected strobe at port", 32'(isa_addr), 32'h0);
               cur = '0;
               cur_tag = "R8";
            end else begin
               cur = cyc_q.pop_front();
               cur_tag = cyc_tag_q.pop_front();
               chk(isa_addr == cur.port, cur_tag, "port", 32'(isa_addr), 32'(cur.port));
               chk(isa_lane == cur.lanes, cur_tag, "lanes", 32'(isa_lane), 32'(cur.lanes));
               chk(!isa_wr_n == cur.wr, {cur_tag, " R9"}, "write strobe",
                   32'(!isa_wr_n), 32'(cur.wr));
               chk(isa_oe == cur.wr, {cur_tag, " R9"}, "oe", 32'(isa_oe), 32'(cur.wr));
               if (cur.wr)
                  chk(isa_dout == cur.dout, cur_tag, "dout", 32'(isa_dout), 32'(cur.dout));
            end
         end
         if (low) run++;
         if (!low && prev_low)
            chk(run == int'(cur.len), {cur_tag, " R9"}, "strobe clocks", 32'(run), 32'(cur.len));
         // R10: valid read data only on the final strobe clock
         if (!isa_rd_n && run == int'(cur.len)) isa_din = periph(isa_addr);
         else isa_din = 16'hBAD0;
         if (cpu_ready) begin
            if (done_q.size() == 0) begin
               chk(1'b0, "R11", "unexpected ready", 32'h1, 32'h0);
            end else begin
               d = done_q.pop_front();
               t = done_tag_q.pop_front();
               chk(cpu_err == d.err, {t, " R11"}, "err", 32'(cpu_err), 32'(d.err));
               if (!d.err && !d.wr)
                  chk(cpu_rdata == d.rd, {t, " R10"}, "rdata", cpu_rdata, d.rd);
            end
         end
         prev_low = low;
      end
   end

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(isa_rd_n && isa_wr_n, "R12", "strobes", {30'h0, isa_rd_n, isa_wr_n}, 32'h3);
      chk(!isa_oe && !cpu_ready, "R12", "oe/ready", {30'h0, isa_oe, cpu_ready}, 32'h0);
      chk(isa_lane == 2'b00, "R12", "lanes", 32'(isa_lane), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      xfer(14'h0440, 2'd0, 1'b1, 32'h0000_005A, 2, "R1");
      xfer(14'h0440, 2'd0, 1'b0, 32'h0, 3, "R1");
      xfer(14'h0440, 2'd2, 1'b1, 32'hFFFF_FFC3, 2, "R2");
      xfer(14'h0440, 2'd2, 1'b0, 32'h0, 1, "R2");
      xfer(14'h04F0, 2'd2, 1'b0, 32'h0, 15, "R2");
      xfer(14'h0441, 2'd0, 1'b1, 32'h0000_0077, 2, "R3");
      xfer(14'h0441, 2'd0, 1'b0, 32'h0, 4, "R3");
      xfer(14'h0FE4, 2'd0, 1'b1, 32'h0000_0011, 2, "R4");
      xfer(14'h0BF4, 2'd0, 1'b0, 32'h0, 3, "R4");
      xfer(14'h0DE8, 2'd0, 1'b0, 32'h0, 0, "R4");
      xfer(14'h0FE0, 2'd1, 1'b1, 32'h0000_BEEF, 2, "R4");
      xfer(14'h0FE1, 2'd0, 1'b1, 32'h0, 2, "R4");
      xfer(14'h0FE0, 2'd2, 1'b0, 32'h0, 2, "R4");
      xfer(14'h0460, 2'd1, 1'b1, 32'h0000_1234, 2, "R5");
      xfer(14'h0460, 2'd1, 1'b0, 32'h0, 5, "R5");
      xfer(14'h0461, 2'd1, 1'b1, 32'h0, 2, "R6");
      xfer(14'h0FE4, 2'd1, 1'b0, 32'h0, 2, "R6");
      xfer(14'h0600, 2'd3, 1'b1, 32'hCAFE_F00D, 2, "R7");
      xfer(14'h0600, 2'd3, 1'b0, 32'h0, 1, "R7");
      xfer(14'h0604, 2'd3, 1'b1, 32'h0, 2, "R7");
      xfer(14'h0442, 2'd0, 1'b1, 32'h0, 2, "R8");
      xfer(14'h2440, 2'd0, 1'b0, 32'h0, 2, "R8");
      xfer(14'h0441, 2'd2, 1'b1, 32'h0, 2, "R8");
      xfer(14'h0660, 2'd1, 1'b1, 32'h0000_A5A5, 15, "R9");

      repeat (4) @(negedge clk);
      chk(cyc_q.size() == 0, "R8", "cycles left", 32'(cyc_q.size()), 32'h0);
      chk(done_q.size() == 0, "R11", "completions left", 32'(done_q.size()), 32'h0);
      summary();
      $finish;
   end
endmodule